// File: doc/BRIEF.md
# Merging Write Store Buffer

The block sits in front of a cache's downstream write path. It gathers byte-granular writes into whole 32-byte lines held in three slots. A later write to a line that is already buffered is folded into the same slot, so many small stores leave as one line transfer. Each slot keeps a byte-valid mask, which travels with the line when the slot is drained.

Control logic decides which slot leaves and when. The triggers are:
- a write tagged as device memory;
- a line whose bytes have all been written;
- pulses for strongly ordered traffic, locked transfers and configuration-register accesses;
- a hazard report naming one slot;
- a demand for a slot when all three are taken, in which case the least recently accessed slot leaves.

A slot that is waiting to drain or is draining no longer accepts merges. A write to its line waits and then starts a new slot. Drained lines leave one at a time over a valid/ready handshake. An `empty` output lets upstream logic wait until nothing is buffered.

Top module: `merge_store_buffer`

## Requirements
- R1: The buffer has three slots. Each slot holds one line address, 256 data bits and a 32-bit mask. On the drain port, mask bit i covers byte i, which is `drnData[8i+7:8i]`. Bytes never written in the current use of a slot are drained as zero.
- R2: A write whose line matches a slot that is not pending drain is merged into that slot. New bytes replace old ones, the mask becomes the OR of the two, and no drain starts on that account.
- R3: A write with `wrDevice`=1 causes its slot to be drained with no further event.
- R4: A slot whose mask becomes all ones is drained with no further event.
- R5: A one-cycle pulse on `soEvent` drains every slot occupied at that edge.
- R6: A pulse on `lockEvent` or on `cfgEvent` drains every slot occupied at that edge.
- R7: With `hazardValid`=1, the occupied slot whose index equals `hazardSlot` is drained, and no other slot is affected.
- R8: Suppose all slots are occupied, none is pending, and a write to a new line arrives. Then the slot least recently allocated or merged into is drained. `wrReady` stays 0 until a slot is free.
- R9: A write to a line whose slot is pending drain keeps `wrReady`=0 until that slot has drained. It then lands in a fresh slot and does not merge with the old data.
- R10: Only one slot is presented at a time. Line, data and mask stay stable while `drnValid`=1 and `drnReady`=0. The slot is freed at the handshake, and `drnValid` is 0 in the following cycle. Pending slots leave lowest index first, and new lines take the lowest free index.
- R11: `empty` is 1 exactly when no slot is occupied.
- R12: A write with all strobes zero is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request valid |
| wrReady | output | 1 | Write request accepted when high with wrValid |
| wrLine | input | LINE_ADDR_W | Line address of the write |
| wrStrb | input | LINE_BYTES | Byte strobes |
| wrData | input | 8*LINE_BYTES | Write data, byte i in bits 8i+7:8i |
| wrDevice | input | 1 | Write targets device memory |
| soEvent | input | 1 | Strongly ordered access seen |
| lockEvent | input | 1 | Locked transaction seen |
| cfgEvent | input | 1 | Configuration-register access seen |
| hazardValid | input | 1 | Hazard reported against hazardSlot |
| hazardSlot | input | 2 | Index of the slot in hazard |
| drnValid | output | 1 | Drain line valid |
| drnReady | input | 1 | Downstream takes the drain line |
| drnLine | output | LINE_ADDR_W | Line address being drained |
| drnData | output | 8*LINE_BYTES | Line data being drained |
| drnMask | output | LINE_BYTES | Byte-valid mask of the drained line |
| empty | output | 1 | No slot occupied |

## Verification
The bench uses the default parameters: 27-bit line addresses, 32-byte lines, and the three slots fixed by the package. With three slots, a fourth line is enough to reach the least-recently-accessed victim path. The victim is also steered by a merge into the oldest slot, which gives an ordering that differs from allocation order. With 32-byte lines, two half-line writes are enough to fill a line, and partial strobe patterns show byte-level merging and zero-fill of unwritten bytes.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  parameter int unsigned WSB_SLOTS = 3;
  localparam int unsigned WSB_IDX_W = $clog2(WSB_SLOTS);

  typedef struct packed {
    logic                 wrEn;
    logic                 wrAlloc;
    logic [WSB_IDX_W-1:0] wrSlot;
    logic                 clrEn;
    logic [WSB_IDX_W-1:0] clrSlot;
    logic [WSB_IDX_W-1:0] rdSlot;
  } wsb_strobe_t;
endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
  import wsb_pkg::*;
#(
  parameter int unsigned LINE_ADDR_W = 27,
  parameter int unsigned LINE_BYTES  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  output logic                       wrReady,
  input  logic [LINE_ADDR_W-1:0]     wrLine,
  input  logic [LINE_BYTES-1:0]      wrStrb,
  input  logic                       wrDevice,
  input  logic                       soEvent,
  input  logic                       lockEvent,
  input  logic                       cfgEvent,
  input  logic                       hazardValid,
  input  logic [WSB_IDX_W-1:0]       hazardSlot,
  input  logic                       fullAfterWr,
  output logic                       drnValid,
  input  logic                       drnReady,
  output logic [LINE_ADDR_W-1:0]     drnLine,
  output logic                       empty,
  output wsb_strobe_t                stb
);
  localparam int unsigned N = WSB_SLOTS;
  localparam int unsigned IW = WSB_IDX_W;
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0]           occQ, markQ, occNext, markNext;
  logic [N-1:0]           setVec, clrVec, allocVec;
  logic [LINE_ADDR_W-1:0] tagQ [N];
  logic [IW-1:0]          rankQ [N];
  logic                   busyQ;
  logic [IW-1:0]          curQ;

  logic          hitAny, hitLive, freeAny, wrAcc, wrTake, needVictim, drnFire, flushAny;
  logic [IW-1:0] hitIdx, freeIdx, selIdx, victimIdx, wrSlot;

  // slot lookup
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (occQ[i] && tagQ[i] == wrLine) begin
        hitAny = 1'b1;
        hitIdx = IW'(i);
      end
    end
  end

  // lowest free, lowest pending, oldest occupied
  always_comb begin
    freeIdx   = '0;
    selIdx    = '0;
    victimIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!occQ[i])  freeIdx = IW'(i);
      if (markQ[i])  selIdx  = IW'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (rankQ[i] == OLDEST) victimIdx = IW'(i);
    end
  end

  assign freeAny    = |(~occQ);
  assign hitLive    = hitAny && !markQ[hitIdx];
  assign wrReady    = hitLive || (!hitAny && freeAny);
  assign wrAcc      = wrValid && wrReady;
  assign wrTake     = wrAcc && (wrStrb != '0);
  assign wrSlot     = hitLive ? hitIdx : freeIdx;
  assign needVictim = wrValid && (wrStrb != '0) && !hitAny && !freeAny && (markQ == '0);
  assign drnFire    = busyQ && drnReady;
  assign flushAny   = soEvent || lockEvent || cfgEvent;

  always_comb begin
    setVec   = '0;
    clrVec   = '0;
    allocVec = '0;
    for (int i = 0; i < N; i++) begin
      if (flushAny && occQ[i])                                        setVec[i] = 1'b1;
      if (hazardValid && hazardSlot == IW'(i))                        setVec[i] = 1'b1;
      if (wrTake && (wrDevice || fullAfterWr) && wrSlot == IW'(i))    setVec[i] = 1'b1;
      if (needVictim && victimIdx == IW'(i))                          setVec[i] = 1'b1;
      if (drnFire && curQ == IW'(i))                                  clrVec[i] = 1'b1;
      if (wrTake && !hitLive && wrSlot == IW'(i))                     allocVec[i] = 1'b1;
    end
  end

  assign occNext  = (occQ & ~clrVec) | allocVec;
  assign markNext = ((markQ & ~clrVec) | setVec) & occNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occQ  <= '0;
      markQ <= '0;
      busyQ <= 1'b0;
      curQ  <= '0;
      for (int i = 0; i < N; i++) begin
        tagQ[i]  <= '0;
        rankQ[i] <= IW'(i);
      end
    end else begin
      occQ  <= occNext;
      markQ <= markNext;
      if (drnFire) begin
        busyQ <= 1'b0;
      end else if (!busyQ && markQ != '0) begin
        busyQ <= 1'b1;
        curQ  <= selIdx;
      end
      for (int i = 0; i < N; i++) begin
        if (allocVec[i]) tagQ[i] <= wrLine;
        if (wrTake) begin
          if (wrSlot == IW'(i))             rankQ[i] <= '0;
          else if (rankQ[i] < rankQ[wrSlot]) rankQ[i] <= rankQ[i] + 1'b1;
        end
      end
    end
  end

  assign drnValid    = busyQ;
  assign drnLine     = tagQ[curQ];
  assign empty       = (occQ == '0);
  assign stb.wrEn    = wrTake;
  assign stb.wrAlloc = !hitLive;
  assign stb.wrSlot  = wrSlot;
  assign stb.clrEn   = drnFire;
  assign stb.clrSlot = curQ;
  assign stb.rdSlot  = curQ;
endmodule

// File: rtl/wsb_data.sv
module wsb_data
  import wsb_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wsb_strobe_t               stb,
  input  logic [LINE_BYTES-1:0]     wrStrb,
  input  logic [8*LINE_BYTES-1:0]   wrData,
  output logic                      fullAfterWr,
  output logic [8*LINE_BYTES-1:0]   drnData,
  output logic [LINE_BYTES-1:0]     drnMask
);
  localparam int unsigned N = WSB_SLOTS;
  localparam int unsigned DW = 8 * LINE_BYTES;

  logic [DW-1:0]         dataQ [N];
  logic [LINE_BYTES-1:0] maskQ [N];
  logic [LINE_BYTES-1:0] baseMask;

  assign baseMask    = stb.wrAlloc ? '0 : maskQ[stb.wrSlot];
  assign fullAfterWr = &(baseMask | wrStrb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        dataQ[i] <= '0;
        maskQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (stb.clrEn && stb.clrSlot == WSB_IDX_W'(i)) maskQ[i] <= '0;
        if (stb.wrEn && stb.wrSlot == WSB_IDX_W'(i)) begin
          maskQ[i] <= baseMask | wrStrb;
          for (int b = 0; b < LINE_BYTES; b++) begin
            if (wrStrb[b])        dataQ[i][8*b +: 8] <= wrData[8*b +: 8];
            else if (stb.wrAlloc) dataQ[i][8*b +: 8] <= 8'h00;
          end
        end
      end
    end
  end

  assign drnData = dataQ[stb.rdSlot];
  assign drnMask = maskQ[stb.rdSlot];
endmodule

// File: rtl/merge_store_buffer.sv
module merge_store_buffer
  import wsb_pkg::*;
#(
  parameter int unsigned LINE_ADDR_W = 27,
  parameter int unsigned LINE_BYTES  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrValid,
  output logic                      wrReady,
  input  logic [LINE_ADDR_W-1:0]    wrLine,
  input  logic [LINE_BYTES-1:0]     wrStrb,
  input  logic [8*LINE_BYTES-1:0]   wrData,
  input  logic                      wrDevice,
  input  logic                      soEvent,
  input  logic                      lockEvent,
  input  logic                      cfgEvent,
  input  logic                      hazardValid,
  input  logic [WSB_IDX_W-1:0]      hazardSlot,
  output logic                      drnValid,
  input  logic                      drnReady,
  output logic [LINE_ADDR_W-1:0]    drnLine,
  output logic [8*LINE_BYTES-1:0]   drnData,
  output logic [LINE_BYTES-1:0]     drnMask,
  output logic                      empty
);
  wsb_strobe_t stb;
  logic        fullAfterWr;

  wsb_ctrl #(.LINE_ADDR_W(LINE_ADDR_W), .LINE_BYTES(LINE_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrReady(wrReady), .wrLine(wrLine), .wrStrb(wrStrb),
    .wrDevice(wrDevice), .soEvent(soEvent), .lockEvent(lockEvent), .cfgEvent(cfgEvent),
    .hazardValid(hazardValid), .hazardSlot(hazardSlot), .fullAfterWr(fullAfterWr),
    .drnValid(drnValid), .drnReady(drnReady), .drnLine(drnLine),
    .empty(empty), .stb(stb)
  );

  wsb_data #(.LINE_BYTES(LINE_BYTES)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrStrb(wrStrb), .wrData(wrData),
    .fullAfterWr(fullAfterWr), .drnData(drnData), .drnMask(drnMask)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int unsigned LINE_ADDR_W = 27,
  parameter int unsigned LINE_BYTES  = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrValid,
  input logic                      wrReady,
  input logic [LINE_BYTES-1:0]     wrStrb,
  input logic                      wrDevice,
  input logic                      drnValid,
  input logic                      drnReady,
  input logic [LINE_ADDR_W-1:0]    drnLine,
  input logic [8*LINE_BYTES-1:0]   drnData,
  input logic [LINE_BYTES-1:0]     drnMask,
  input logic                      empty
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    drnValid && !drnReady |=> drnValid && $stable(drnLine) && $stable(drnData) && $stable(drnMask));

  a_r10_gap_after_take: assert property (@(posedge clk) disable iff (!rstN)
    drnValid && drnReady |=> !drnValid);

  a_r11_empty_no_drain: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !drnValid);

  a_r1_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    drnValid |-> drnMask != '0);

  a_r3_device_held: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrReady && wrDevice && (wrStrb != '0) |=> !empty);

  a_r12_zero_strobe_drop: assert property (@(posedge clk) disable iff (!rstN)
    empty && (!wrValid || wrStrb == '0) |=> empty);
endmodule

bind merge_store_buffer wsb_checker #(.LINE_ADDR_W(LINE_ADDR_W), .LINE_BYTES(LINE_BYTES)) i_wsb_checker (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .wrStrb(wrStrb),
  .wrDevice(wrDevice), .drnValid(drnValid), .drnReady(drnReady), .drnLine(drnLine),
  .drnData(drnData), .drnMask(drnMask), .empty(empty)
);

// File: tb/test_merge_store_buffer.sv
`timescale 1ns/1ps
module test_merge_store_buffer;
  localparam int LA = 27;
  localparam int LB = 32;
  localparam int DW = 8 * LB;

  logic clk = 0;
  logic rstN = 0;
  logic wrValid = 0, wrDevice = 0, soEvent = 0, lockEvent = 0, cfgEvent = 0, hazardValid = 0;
  logic [LA-1:0] wrLine = '0;
  logic [LB-1:0] wrStrb = '0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    hazardSlot = '0;
  logic drnReady = 0;
  logic wrReady, drnValid, empty;
  logic [LA-1:0] drnLine;
  logic [DW-1:0] drnData;
  logic [LB-1:0] drnMask;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  merge_store_buffer #(.LINE_ADDR_W(LA), .LINE_BYTES(LB)) i_merge_store_buffer (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .wrLine(wrLine),
    .wrStrb(wrStrb), .wrData(wrData), .wrDevice(wrDevice), .soEvent(soEvent),
    .lockEvent(lockEvent), .cfgEvent(cfgEvent), .hazardValid(hazardValid),
    .hazardSlot(hazardSlot), .drnValid(drnValid), .drnReady(drnReady),
    .drnLine(drnLine), .drnData(drnData), .drnMask(drnMask), .empty(empty)
  );

  function automatic logic [DW-1:0] pat(input logic [7:0] seed);
    logic [DW-1:0] v;
    for (int b = 0; b < LB; b++) v[8*b +: 8] = seed + 8'(b * 7);
    return v;
  endfunction

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old, input logic [DW-1:0] nd,
                                        input logic [LB-1:0] strb);
    logic [DW-1:0] v = old;
    for (int b = 0; b < LB; b++) if (strb[b]) v[8*b +: 8] = nd[8*b +: 8];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [LA-1:0] ln, input logic [LB-1:0] st,
                         input logic [DW-1:0] d, input logic dev);
    int n = 0;
    @(negedge clk);
    wrValid = 1; wrLine = ln; wrStrb = st; wrData = d; wrDevice = dev;
    while (!wrReady && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) chk(0, "write accept", 0, 1);
    @(posedge clk);
    @(negedge clk);
    wrValid = 0; wrDevice = 0;
  endtask

  task automatic getDrain(input string req, input logic [LA-1:0] eLine,
                          input logic [LB-1:0] eMask, input logic [DW-1:0] eData);
    int n = 0;
    @(negedge clk);
    drnReady = 1;
    while (!drnValid && n < 200) begin @(negedge clk); n++; end
    chk(drnValid, {req, " drain valid"}, DW'(drnValid), 1);
    chk(drnLine == eLine, {req, " line"}, DW'(drnLine), DW'(eLine));
    chk(drnMask == eMask, {req, " mask"}, DW'(drnMask), DW'(eMask));
    chk(drnData == eData, {req, " data"}, drnData, eData);
    @(posedge clk);
    @(negedge clk);
    drnReady = 0;
    chk(!drnValid, "R10 gap after take", DW'(drnValid), 0);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // R11 reset state
  task automatic tReset();
    @(negedge clk);
    chk(empty, "R11 empty after reset", DW'(empty), 1);
    chk(!drnValid, "R10 no drain after reset", DW'(drnValid), 0);
    chk(wrReady, "R1 ready after reset", DW'(wrReady), 1);
  endtask

  // R2 merge, R5 strongly ordered flush
  task automatic tMerge();
    logic [DW-1:0] e;
    doWrite(27'h100, 32'h000000FF, pat(8'h11), 0);
    doWrite(27'h100, 32'h0000FF0F, pat(8'h22), 0);
    idle(4);
    chk(!drnValid && !empty, "R2 merged slot kept", DW'(drnValid), 0);
    e = mrg(mrg('0, pat(8'h11), 32'h000000FF), pat(8'h22), 32'h0000FF0F);
    @(negedge clk); soEvent = 1; @(negedge clk); soEvent = 0;
    getDrain("R5/R2", 27'h100, 32'h0000FFFF, e);
    chk(empty, "R11 empty after flush", DW'(empty), 1);
  endtask

  // R4 full line
  task automatic tFull();
    doWrite(27'h200, 32'h0000FFFF, pat(8'h33), 0);
    doWrite(27'h200, 32'hFFFF0000, pat(8'h44), 0);
    getDrain("R4", 27'h200, 32'hFFFFFFFF,
             mrg(mrg('0, pat(8'h33), 32'h0000FFFF), pat(8'h44), 32'hFFFF0000));
  endtask

  // R3 device write
  task automatic tDevice();
    doWrite(27'h300, 32'h0000F000, pat(8'h55), 1);
    getDrain("R3", 27'h300, 32'h0000F000, mrg('0, pat(8'h55), 32'h0000F000));
  endtask

  // R8 least recently accessed victim, R6 cfg flush, R10 order
  task automatic tVictim();
    logic [DW-1:0] e0;
    doWrite(27'h400, 32'h00000001, pat(8'h01), 0);
    doWrite(27'h401, 32'h00000002, pat(8'h02), 0);
    doWrite(27'h402, 32'h00000004, pat(8'h03), 0);
    doWrite(27'h400, 32'h00000100, pat(8'h04), 0);
    e0 = mrg(mrg('0, pat(8'h01), 32'h00000001), pat(8'h04), 32'h00000100);
    @(negedge clk);
    wrValid = 1; wrLine = 27'h403; wrStrb = 32'h00000010; wrData = pat(8'h05);
    idle(4);
    chk(!wrReady, "R8 stall while all taken", DW'(wrReady), 0);
    chk(drnValid && drnLine == 27'h401, "R8 victim line", DW'(drnLine), DW'(27'h401));
    drnReady = 1;
    @(posedge clk);
    @(negedge clk);
    drnReady = 0;
    chk(wrReady, "R8 ready after victim leaves", DW'(wrReady), 1);
    @(posedge clk);
    @(negedge clk);
    wrValid = 0;
    @(negedge clk); cfgEvent = 1; @(negedge clk); cfgEvent = 0;
    getDrain("R6/R10 slot0", 27'h400, 32'h00000101, e0);
    getDrain("R6/R10 slot1", 27'h403, 32'h00000010, mrg('0, pat(8'h05), 32'h00000010));
    getDrain("R6/R10 slot2", 27'h402, 32'h00000004, mrg('0, pat(8'h03), 32'h00000004));
  endtask

  // R7 hazard, R6 lock flush
  task automatic tHazard();
    doWrite(27'h500, 32'h000000F0, pat(8'h66), 0);
    doWrite(27'h501, 32'h00F00000, pat(8'h77), 0);
    @(negedge clk); hazardValid = 1; hazardSlot = 2'd1; @(negedge clk); hazardValid = 0;
    getDrain("R7", 27'h501, 32'h00F00000, mrg('0, pat(8'h77), 32'h00F00000));
    idle(3);
    chk(!empty && !drnValid, "R7 other slot untouched", DW'(empty), 0);
    @(negedge clk); lockEvent = 1; @(negedge clk); lockEvent = 0;
    getDrain("R6 lock", 27'h500, 32'h000000F0, mrg('0, pat(8'h66), 32'h000000F0));
    chk(empty, "R11 empty after lock flush", DW'(empty), 1);
  endtask

  // R9 no merge into a pending slot
  task automatic tNoMerge();
    doWrite(27'h600, 32'h0000FFFF, pat(8'h88), 0);
    @(negedge clk); hazardValid = 1; hazardSlot = 2'd0; @(negedge clk); hazardValid = 0;
    wrValid = 1; wrLine = 27'h600; wrStrb = 32'hFF000000; wrData = pat(8'h99);
    idle(3);
    chk(!wrReady, "R9 stall on pending line", DW'(wrReady), 0);
    getDrain("R9 old", 27'h600, 32'h0000FFFF, mrg('0, pat(8'h88), 32'h0000FFFF));
    chk(wrReady, "R9 ready after drain", DW'(wrReady), 1);
    @(posedge clk);
    @(negedge clk);
    wrValid = 0;
    @(negedge clk); soEvent = 1; @(negedge clk); soEvent = 0;
    getDrain("R9 fresh", 27'h600, 32'hFF000000, mrg('0, pat(8'h99), 32'hFF000000));
  endtask

  // R12 zero-strobe write
  task automatic tZero();
    doWrite(27'h700, 32'h00000000, pat(8'hAA), 1);
    idle(3);
    chk(empty && !drnValid, "R12 zero strobe ignored", DW'(empty), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    tReset();
    tMerge();
    tFull();
    tDevice();
    tVictim();
    tHazard();
    tNoMerge();
    tZero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule